// File: doc/BRIEF.md
# Character-Mode Text Video Generator

This block paints a VGA raster from a grid of character codes rather than from a pixel buffer. A raster timer walks the horizontal and vertical counters and produces active-low sync pulses and a visible-area flag. A two-port cell memory holds one byte per text cell. The host writes that memory through a small address/data port and can read it back. The scan side reads it continuously. Each scanned code selects a glyph, the current scan line inside the cell selects one 8-pixel row of that glyph, and the column inside the cell picks one bit of that row.

The two lookups are both synchronous: the cell read takes one clock and the glyph row read takes another. The sync pulses, the visible flag and the in-cell pixel column therefore travel through two pipeline stages alongside them, so that every output pin refers to the same raster position. The low seven bits of a cell byte are the glyph index. The top bit picks the foreground colour. The background is always black.

The default timing is 640x480 at 800x525 total with a 25 MHz pixel clock, giving an 80x60 grid of 8x8 cells. Every porch, sync and visible length is a parameter, so smaller rasters can be built.

Top module: `text_vga_top`

## Requirements
- R1: `hsync_n` is low for exactly H_SYNC clocks of each H_TOT-clock line, starting H_VIS+H_FP clocks after the line starts, and high at all other times.
- R2: `vsync_n` is low during lines V_VIS+V_FP through V_VIS+V_FP+V_SYNC-1 of each V_TOT-line frame, and high on every other line.
- R3: While `rst` is high, and for the first two clocks after it is released, `hsync_n` and `vsync_n` are 1 and `rgb` is 0. After that, every output shows raster position p exactly two clocks after the counters held p. Position 0 is line 0, column 0, and it is held during reset.
- R4: `rgb` is 3'b000 at every raster position outside columns 0..H_VIS-1 of lines 0..V_VIS-1.
- R5: At a visible position (x, y), the cell index is (y/8)*(H_VIS/8) + x/8. The glyph row byte for code c and glyph row r = y%8 is ({c[6:0], r[0]} XOR {r, 5'b0}). The pixel is bit 7-(x%8) of that byte, so bit 7 is the leftmost pixel. When that bit is 0, `rgb` is 3'b000.
- R6: When the selected glyph bit is 1, `rgb` is 3'b111 if bit 7 of the cell byte is 0, and 3'b110 if it is 1. `rgb[2]` is red, `rgb[1]` is green and `rgb[0]` is blue.
- R7: A host write (`cpu_we`=1) stores `cpu_wdata` at `cpu_addr` on the clock edge. `cpu_rdata` shows the byte at the `cpu_addr` presented at the previous edge, as it was before any write made on that same edge.
- R8: A `cpu_addr` at or above (H_VIS/8)*(V_VIS/8) changes no cell when written, and reads back as 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_we | input | 1 | Host write strobe |
| cpu_addr | input | CPU_AW | Host cell index |
| cpu_wdata | input | 8 | Host write byte: bit 7 selects the colour, bits 6..0 are the glyph index |
| cpu_rdata | output | 8 | Host read byte, one clock after the address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 3 | Pixel colour: red, green, blue |

## Verification
The bench builds the raster on a non-power-of-two grid of 6x4 cells, so a cell index computed by concatenating fields instead of multiplying by the column count lands on the wrong byte and shows wrong glyphs. The expected picture is predicted at exactly two clocks of lag. A design that delays the syncs or the pixel column by one clock instead of two shifts every glyph sideways or moves the sync edges, and the pixel or sync checks catch it. Directed cells cover the last column, the last cell, an all-zero code and the alternate colour; a reversed bit order or a swapped colour choice shows up there. Writes and reads above the last cell are checked to leave every cell unchanged and to return zero, which exposes any address folding.

// File: rtl/text_vga_pkg.sv
package text_vga_pkg;
  localparam int GLYPH_W  = 8;
  localparam int GLYPH_H  = 8;
  localparam int GW_BITS  = $clog2(GLYPH_W);
  localparam int GH_BITS  = $clog2(GLYPH_H);
  localparam int CODE_W   = 7;
  localparam int CELL_W   = CODE_W + 1;

  typedef logic [2:0] rgb_t;
  localparam rgb_t FG_PLAIN = 3'b111;
  localparam rgb_t FG_ALT   = 3'b110;
  localparam rgb_t BLACK    = 3'b000;

  // Synthetic font: one byte per glyph row, MSB is the leftmost pixel.
  function automatic logic [GLYPH_W-1:0] glyph_row_bits(input logic [CODE_W-1:0] code,
                                                        input logic [GH_BITS-1:0] row);
    return {code, row[0]} ^ {row, 5'b00000};
  endfunction

  function automatic rgb_t fg_colour(input logic alt);
    return alt ? FG_ALT : FG_PLAIN;
  endfunction

  // Active-low pulse: low while start <= cnt < start+len.
  function automatic logic sync_level(input int cnt, input int start, input int len);
    return !((cnt >= start) && (cnt < start + len));
  endfunction
endpackage

// File: rtl/vga_raster_timer.sv
module vga_raster_timer import text_vga_pkg::*; #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT)
)(
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          active,
  output logic          hs_n,
  output logic          vs_n
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_VIS_C = HW'(H_VIS);
  localparam logic [VW-1:0] V_VIS_C = VW'(V_VIS);

  logic line_end, frame_end;
  assign line_end  = (h_pos == H_LAST);
  assign frame_end = line_end && (v_pos == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (line_end) begin
      h_pos <= '0;
      v_pos <= frame_end ? '0 : v_pos + 1'b1;
    end else begin
      h_pos <= h_pos + 1'b1;
    end
  end

  assign active = (h_pos < H_VIS_C) && (v_pos < V_VIS_C);
  assign hs_n   = sync_level(int'(h_pos), H_VIS + H_FP, H_SYNC);
  assign vs_n   = sync_level(int'(v_pos), V_VIS + V_FP, V_SYNC);

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (h_pos == H_LAST) |=> (h_pos == '0));
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    ((h_pos == H_LAST) && (v_pos == V_LAST)) |=> (v_pos == '0));
  a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
    (h_pos != H_LAST) |=> $stable(v_pos));
endmodule

// File: rtl/text_cell_ram.sv
module text_cell_ram #(
  parameter int DEPTH = 4800,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic a_in;
  assign a_in = ({1'b0, a_addr} < (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (a_we && a_in) mem[a_addr] <= a_wdata;
    a_rdata <= a_in ? mem[a_addr] : '0;
    b_rdata <= mem[b_addr];
  end

  // R7: a write followed by a read of the same cell returns the written byte
  a_r7_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(a_we) && $past(a_in) && !a_we && (a_addr == $past(a_addr)))
      |=> (a_rdata == $past(a_wdata, 2)));
  a_r8_oob_zero: assert property (@(posedge clk) disable iff (rst)
    !a_in |=> (a_rdata == '0));
endmodule

// File: rtl/glyph_row_rom.sv
module glyph_row_rom import text_vga_pkg::*; (
  input  logic               clk,
  input  logic [CODE_W-1:0]  code,
  input  logic [GH_BITS-1:0] row,
  output logic [GLYPH_W-1:0] bits
);
  always_ff @(posedge clk) bits <= glyph_row_bits(code, row);
endmodule

// File: rtl/text_vga_top.sv
module text_vga_top import text_vga_pkg::*; #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int TEXT_COLS = H_VIS / GLYPH_W,
  localparam int TEXT_ROWS = V_VIS / GLYPH_H,
  localparam int CELLS     = TEXT_COLS * TEXT_ROWS,
  localparam int CPU_AW    = $clog2(CELLS),
  localparam int HW        = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  localparam int VW        = $clog2(V_VIS + V_FP + V_SYNC + V_BP)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CELL_W-1:0] cpu_wdata,
  output logic [CELL_W-1:0] cpu_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic [2:0]        rgb
);
  // stage 0: raster counters
  logic [HW-1:0] t_h;
  logic [VW-1:0] t_v;
  logic t_act, t_hs, t_vs;

  vga_raster_timer #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timer (
    .clk(clk), .rst(rst), .h_pos(t_h), .v_pos(t_v),
    .active(t_act), .hs_n(t_hs), .vs_n(t_vs)
  );

  function automatic logic [CPU_AW-1:0] cell_index(input logic [HW-1:0] h, input logic [VW-1:0] v);
    return CPU_AW'(int'(v >> GH_BITS) * TEXT_COLS + int'(h >> GW_BITS));
  endfunction

  logic [CPU_AW-1:0] scan_addr;
  assign scan_addr = t_act ? cell_index(t_h, t_v) : '0;

  // stage 1: cell byte read
  logic [CELL_W-1:0]  s1_code;
  logic [GH_BITS-1:0] s1_row;
  logic [GW_BITS-1:0] s1_px;
  logic s1_act, s1_hs, s1_vs;

  text_cell_ram #(.DEPTH(CELLS), .DW(CELL_W)) u_cells (
    .clk(clk), .rst(rst),
    .a_we(cpu_we), .a_addr(cpu_addr), .a_wdata(cpu_wdata), .a_rdata(cpu_rdata),
    .b_addr(scan_addr), .b_rdata(s1_code)
  );

  // stage 2: glyph row read
  logic [GLYPH_W-1:0] s2_bits;
  logic [GW_BITS-1:0] s2_px;
  logic s2_act, s2_hs, s2_vs, s2_alt;

  glyph_row_rom u_font (
    .clk(clk), .code(s1_code[CODE_W-1:0]), .row(s1_row), .bits(s2_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_row <= '0; s1_px <= '0; s1_act <= 1'b0; s1_hs <= 1'b1; s1_vs <= 1'b1;
      s2_px  <= '0; s2_act <= 1'b0; s2_hs <= 1'b1; s2_vs <= 1'b1; s2_alt <= 1'b0;
    end else begin
      s1_row <= t_v[GH_BITS-1:0];
      s1_px  <= t_h[GW_BITS-1:0];
      s1_act <= t_act;
      s1_hs  <= t_hs;
      s1_vs  <= t_vs;
      s2_px  <= s1_px;
      s2_act <= s1_act;
      s2_hs  <= s1_hs;
      s2_vs  <= s1_vs;
      s2_alt <= s1_code[CELL_W-1];
    end
  end

  logic pix_on;
  assign pix_on  = s2_bits[GW_BITS'(GLYPH_W - 1) - s2_px];
  assign rgb     = (s2_act && pix_on) ? fg_colour(s2_alt) : BLACK;
  assign hsync_n = s2_hs;
  assign vsync_n = s2_vs;

  a_r3_hsync_lag: assert property (@(posedge clk) disable iff (rst)
    hsync_n == $past(t_hs, 2));
  a_r3_vsync_lag: assert property (@(posedge clk) disable iff (rst)
    vsync_n == $past(t_vs, 2));
  a_r4_blank: assert property (@(posedge clk) disable iff (rst)
    !$past(t_act, 2) |-> (rgb == BLACK));
endmodule

// File: tb/sim_text_vga_top.sv
`timescale 1ns/1ps
module sim_text_vga_top;
  localparam int HV = 48, HF = 4, HS = 8, HB = 4;
  localparam int VV = 32, VF = 2, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int COLS = HV / 8, ROWS = VV / 8, CELLS = COLS * ROWS;
  localparam int AW = $clog2(CELLS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic hsync_n, vsync_n;
  logic [2:0] rgb;

  always #2.5 clk = ~clk;

  text_vga_top #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) u0 (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
  );

  int errors = 0;
  int checks = 0;
  int edges = 0;
  bit run_sync = 0;
  bit run_pix = 0;
  bit finished = 0;
  logic [7:0] shadow [CELLS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 30) $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, edges, act, exp);
    end
  endtask

  function automatic int ref_glyph(input int code, input int row);
    return (((code & 127) * 2) + (row % 2)) ^ ((row * 32) & 255);
  endfunction

  function automatic int ref_pixel(input int x, input int y, output string tag);
    int c, b;
    if (x >= HV || y >= VV) begin tag = "R4"; return 0; end
    c = int'(shadow[(y / 8) * COLS + (x / 8)]);
    b = (ref_glyph(c, y % 8) >> (7 - (x % 8))) & 1;
    if (b == 0) begin tag = "R5"; return 0; end
    tag = "R6";
    return (c >= 128) ? 6 : 7;
  endfunction

  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  // Outputs after edge n show raster position n-2.
  always @(negedge clk) begin
    if (run_sync && !rst) begin
      int q, x, y, ehs, evs, erg;
      string tg;
      if (edges < 2) begin
        ehs = 1; evs = 1; erg = 0; tg = "R3";
      end else begin
        q = edges - 2;
        x = q % HT;
        y = (q / HT) % VT;
        ehs = (x >= HV + HF && x < HV + HF + HS) ? 0 : 1;
        evs = (y >= VV + VF && y < VV + VF + VS) ? 0 : 1;
        erg = ref_pixel(x, y, tg);
      end
      check(hsync_n == ehs[0], "R1", int'(hsync_n), ehs);
      check(vsync_n == evs[0], "R2", int'(vsync_n), evs);
      if (run_pix || edges < 2) check(rgb == erg[2:0], tg, int'(rgb), erg);
    end
  end

  task automatic cpu_write(input int a, input int d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = 8'(d);
    if (a < CELLS) shadow[a] = 8'(d);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input int a, input int exp, input string req);
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = AW'(a);
    @(negedge clk);
    check(cpu_rdata == 8'(exp), req, int'(cpu_rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd731));
    repeat (4) @(negedge clk);
    // R3: reset state
    check(hsync_n == 1'b1, "R3", int'(hsync_n), 1);
    check(vsync_n == 1'b1, "R3", int'(vsync_n), 1);
    check(rgb == 3'b000, "R3", int'(rgb), 0);
    rst = 1'b0;
    run_sync = 1;

    // fill all cells, then directed corners
    for (int i = 0; i < CELLS; i++) cpu_write(i, int'($urandom % 256));
    cpu_write(0, 8'h00);
    cpu_write(COLS - 1, 8'hFF);
    cpu_write(CELLS - 1, 8'hC1);
    cpu_write(COLS, 8'h7F);
    // R7: readback including write-then-read of the same cell
    cpu_read(0, 8'h00, "R7");
    cpu_read(COLS - 1, 8'hFF, "R7");
    cpu_read(CELLS - 1, 8'hC1, "R7");
    cpu_write(7, 8'h5A);
    cpu_read(7, 8'h5A, "R7");
    // R7: read on the same edge as a write returns the old byte
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = AW'(7); cpu_wdata = 8'hA5; shadow[7] = 8'hA5;
    @(negedge clk);
    cpu_we = 1'b0;
    check(cpu_rdata == 8'h5A, "R7", int'(cpu_rdata), 8'h5A);
    cpu_read(7, 8'hA5, "R7");

    // R8: out-of-range writes change nothing and read back zero
    cpu_write(CELLS, 8'h3C);
    cpu_write((1 << AW) - 1, 8'hE7);
    cpu_read(CELLS, 0, "R8");
    cpu_read((1 << AW) - 1, 0, "R8");
    for (int i = 0; i < CELLS; i++) cpu_read(i, int'(shadow[i]), "R8");

    repeat (4) @(negedge clk);
    run_pix = 1;
    repeat (2 * HT * VT) @(negedge clk);

    run_pix = 0;
    for (int k = 0; k < 10; k++) cpu_write(int'($urandom % CELLS), int'($urandom % 256));
    repeat (4) @(negedge clk);
    run_pix = 1;
    repeat (HT * VT + 10) @(negedge clk);

    run_sync = 0;
    run_pix = 0;
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule